// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Execution Unit

This unit executes the 64-bit atomic pair "load-reserved" (LR) and "store-conditional" (SC) in word and doubleword sizes. It accepts one decoded-from-raw instruction at a time together with the two source register values. It drives a simple memory request/response port and a single register-file write port. It holds exactly one reservation: an LR records the address and size it read, and a later SC with the same address and size succeeds and performs its write. Any other SC fails without touching memory.

The SC outcome is written to the destination register before or together with the first memory activity. A failed SC never reaches the memory port. The acquire and release ordering bits from the instruction travel with every memory request, so the memory system can build ordered variants of each access. The unit does not track coherence itself. An external clear input, driven for instance by a snoop hit or a trap, drops the reservation.

Top module: `lrsc_unit`

## Requirements
- R1: Only opcode 0101111 with funct3 010 (word) or 011 (doubleword) is accepted. funct5 00010 with bits 24:20 equal to zero is LR, and funct5 00011 is SC. Any other instruction raises `illegal` for one cycle, in the cycle after acceptance, with no memory request and no register write.
- R2: An LR issues one read request (`mem_req_we`=0) at exactly `in_rs1`, with `mem_req_dword` set for doubleword. `mem_req_aq` is taken from instruction bit 26 and `mem_req_rl` from bit 25. The request is held stable until `mem_req_ready`.
- R3: One cycle after `mem_rsp_valid`, the LR writes rd (instruction bits 11:7). A word LR writes bits 31:0 of the response, sign-extended to 64 bits. A doubleword LR writes all 64 bits. The LR then sets the reservation to its address and size.
- R4: An SC succeeds only when a reservation is valid and its address and size both equal those of the SC. Otherwise it fails.
- R5: One cycle after acceptance, an SC writes rd with the value 0 on success or 1 on failure, zero-extended. This happens no later than the first cycle of its write request.
- R6: A failed SC issues no memory request of any kind.
- R7: A successful SC issues one write request at `in_rs1`, carrying the instruction's aq and rl bits. A word SC sends rs2 bits 31:0 with data bits 63:32 zero. A doubleword SC sends all of rs2.
- R8: Every aligned, legal SC, whether it succeeds or fails, clears the reservation, so a second SC to the same place fails.
- R9: `clear_resv` drops the reservation. If it is high when an SC is accepted, that SC fails. If it is high in the cycle of an LR response, the clear wins and no reservation is left.
- R10: A word LR/SC whose address is not 4-byte aligned, or a doubleword one not 8-byte aligned, raises `misaligned` for one cycle. It issues no request, writes no register and leaves the reservation unchanged.
- R11: After reset, `in_ready` is 1, no request or register write is pending, and no reservation is held. `in_ready` is 0 while an LR or a successful SC is in flight, and no request is presented while `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle; an offered instruction is taken |
| in_insn | input | 32 | Raw instruction word |
| in_rs1 | input | XLEN | Address source register value |
| in_rs2 | input | XLEN | Store data source register value |
| clear_resv | input | 1 | Drop the reservation |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write (SC), 0 = read (LR) |
| mem_req_dword | output | 1 | 1 = doubleword, 0 = word |
| mem_req_addr | output | XLEN | Byte address |
| mem_req_wdata | output | XLEN | Write data |
| mem_req_aq | output | 1 | Acquire ordering bit |
| mem_req_rl | output | 1 | Release ordering bit |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | XLEN | Read data |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 5 | Destination register index |
| rf_wdata | output | XLEN | Destination register value |
| misaligned | output | 1 | Misaligned access pulse |
| illegal | output | 1 | Unrecognised instruction pulse |

## Verification
The assertions watch properties that must hold on every cycle. A stalled request keeps its fields. Request addresses are always aligned. A word write never carries upper data bits. The first cycle of a write request coincides with a success status of 0 on the register port. The result, misaligned and illegal strobes never coincide. Nothing is requested while the unit is idle. Which SC should succeed depends on the reservation history, so only the bench scenarios can show it, by comparing against a model of the reservation. That covers a mismatch in size or address, a clear at acceptance or at the LR response, reservation survival across a misaligned SC, and the sign-extended load values.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    localparam logic [6:0] AMO_OPC      = 7'b0101111;
    localparam logic [4:0] F5_LOAD_RSV  = 5'b00010;
    localparam logic [4:0] F5_STORE_CND = 5'b00011;
    localparam logic [2:0] F3_WORD      = 3'b010;
    localparam logic [2:0] F3_DWORD     = 3'b011;
    localparam int         RD_W         = 5;
    localparam int         WORD_W       = 32;

    typedef enum logic [1:0] {
        K_LOAD_RSV,
        K_STORE_CND,
        K_BAD
    } kind_e;

    typedef struct packed {
        kind_e           kind;
        logic            dword;
        logic            aq;
        logic            rl;
        logic [RD_W-1:0] rd;
    } dec_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RD_REQ,
        S_RD_WAIT,
        S_WR_REQ
    } state_e;

endpackage

// File: rtl/lrsc_decode.sv
// Instruction classifier for the atomic pair.
// Does: splits a raw 32-bit word into kind, size, ordering bits and rd.
// Assumes: purely combinational; the caller decides when the result is used.
module lrsc_decode
    import lrsc_pkg::*;
(
    input  logic [31:0] insn,
    output dec_t        dec
);

    logic [6:0] opc;
    logic [2:0] f3;
    logic [4:0] f5;
    logic [4:0] src2;
    logic       form_ok;

    assign opc  = insn[6:0];
    assign f3   = insn[14:12];
    assign f5   = insn[31:27];
    assign src2 = insn[24:20];

    // Legal major opcode with a supported size
    assign form_ok = (opc == AMO_OPC) && ((f3 == F3_WORD) || (f3 == F3_DWORD));

    // Build the decoded record
    always_comb begin
        dec.kind  = K_BAD;
        dec.dword = (f3 == F3_DWORD);
        dec.aq    = insn[26];
        dec.rl    = insn[25];
        dec.rd    = insn[11:7];
        if (form_ok && (f5 == F5_LOAD_RSV) && (src2 == 5'd0)) begin
            dec.kind = K_LOAD_RSV;
        end else if (form_ok && (f5 == F5_STORE_CND)) begin
            dec.kind = K_STORE_CND;
        end
    end

endmodule

// File: rtl/lrsc_resv.sv
// Single reservation register.
// Does: holds one address/size pair with a valid bit and compares an SC against it.
// Assumes: set and consume never occur in the same cycle; an external drop
//          overrides a set and also masks the compare in its own cycle.
module lrsc_resv #(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drop_i,
    input  logic          consume_i,
    input  logic          set_i,
    input  logic [AW-1:0] set_addr_i,
    input  logic          set_dword_i,
    input  logic [AW-1:0] chk_addr_i,
    input  logic          chk_dword_i,
    output logic          hit_o
);

    logic          valid_q;
    logic [AW-1:0] addr_q;
    logic          dword_q;

    // Reservation state: drop and consume have priority over a new set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            dword_q <= 1'b0;
        end else if (drop_i || consume_i) begin
            valid_q <= 1'b0;
        end else if (set_i) begin
            valid_q <= 1'b1;
            addr_q  <= set_addr_i;
            dword_q <= set_dword_i;
        end
    end

    // Match on address and size, masked by a same-cycle drop
    assign hit_o = valid_q && !drop_i
                && (addr_q == chk_addr_i) && (dword_q == chk_dword_i);

endmodule

// File: rtl/lrsc_ctrl.sv
// Sequencer for LR and SC.
// Does: accepts one instruction when idle, screens illegal and misaligned
//       ones, runs the read or write handshake, and drives the register write.
// Assumes: memory answers each read with exactly one response, never before
//          the request handshake; writes need no response.
module lrsc_ctrl
    import lrsc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  dec_t            dec,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] rs2,
    input  logic            hit_i,
    output logic            consume_o,
    output logic            set_o,
    output logic [XLEN-1:0] set_addr_o,
    output logic            set_dword_o,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic            mem_req_we,
    output logic            mem_req_dword,
    output logic [XLEN-1:0] mem_req_addr,
    output logic [XLEN-1:0] mem_req_wdata,
    output logic            mem_req_aq,
    output logic            mem_req_rl,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_rdata,
    output logic            rf_we,
    output logic [RD_W-1:0] rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            misaligned,
    output logic            illegal
);

    localparam int WORD_LG  = 2;
    localparam int DWORD_LG = 3;
    localparam int UPPER_W  = XLEN - WORD_W;

    state_e          state_q;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] wdata_q;
    logic            dword_q;
    logic            aq_q;
    logic            rl_q;
    logic            accept;
    logic            aligned;
    logic            is_atomic;
    logic [XLEN-1:0] load_ext;
    logic [XLEN-1:0] store_data;

    assign in_ready  = (state_q == S_IDLE);
    assign accept    = in_valid && in_ready;
    assign is_atomic = (dec.kind == K_LOAD_RSV) || (dec.kind == K_STORE_CND);

    // Natural alignment test for the selected size
    always_comb begin
        if (dec.dword) aligned = (rs1[DWORD_LG-1:0] == '0);
        else           aligned = (rs1[WORD_LG-1:0] == '0);
    end

    // Word loads are sign-extended, doubleword loads pass through
    always_comb begin
        if (dword_q) load_ext = mem_rsp_rdata;
        else         load_ext = {{UPPER_W{mem_rsp_rdata[WORD_W-1]}}, mem_rsp_rdata[WORD_W-1:0]};
    end

    // Word stores send only the low half of rs2
    always_comb begin
        if (dec.dword) store_data = rs2;
        else           store_data = {{UPPER_W{1'b0}}, rs2[WORD_W-1:0]};
    end

    assign consume_o   = accept && (dec.kind == K_STORE_CND) && aligned;
    assign set_o       = (state_q == S_RD_WAIT) && mem_rsp_valid;
    assign set_addr_o  = addr_q;
    assign set_dword_o = dword_q;

    assign mem_req_valid = (state_q == S_RD_REQ) || (state_q == S_WR_REQ);
    assign mem_req_we    = (state_q == S_WR_REQ);
    assign mem_req_dword = dword_q;
    assign mem_req_addr  = addr_q;
    assign mem_req_wdata = wdata_q;
    assign mem_req_aq    = aq_q;
    assign mem_req_rl    = rl_q;

    // Sequencer state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (accept && is_atomic && aligned) begin
                        if (dec.kind == K_LOAD_RSV) state_q <= S_RD_REQ;
                        else if (hit_i)             state_q <= S_WR_REQ;
                    end
                end
                S_RD_REQ:  if (mem_req_ready) state_q <= S_RD_WAIT;
                S_RD_WAIT: if (mem_rsp_valid) state_q <= S_IDLE;
                S_WR_REQ:  if (mem_req_ready) state_q <= S_IDLE;
                default:   state_q <= S_IDLE;
            endcase
        end
    end

    // Request fields captured at acceptance and held for the handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            dword_q <= 1'b0;
            aq_q    <= 1'b0;
            rl_q    <= 1'b0;
        end else if (accept && is_atomic && aligned) begin
            addr_q  <= rs1;
            wdata_q <= store_data;
            dword_q <= dec.dword;
            aq_q    <= dec.aq;
            rl_q    <= dec.rl;
        end
    end

    // Register-file write and fault strobes, one cycle wide
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_we      <= 1'b0;
            rf_waddr   <= '0;
            rf_wdata   <= '0;
            misaligned <= 1'b0;
            illegal    <= 1'b0;
        end else begin
            rf_we      <= 1'b0;
            misaligned <= 1'b0;
            illegal    <= 1'b0;
            if (accept && !is_atomic) begin
                illegal <= 1'b1;
            end else if (accept && !aligned) begin
                misaligned <= 1'b1;
            end else if (accept) begin
                rf_waddr <= dec.rd;
                if (dec.kind == K_STORE_CND) begin
                    rf_we    <= 1'b1;
                    rf_wdata <= {{(XLEN-1){1'b0}}, !hit_i};
                end
            end else if (set_o) begin
                rf_we    <= 1'b1;
                rf_wdata <= load_ext;
            end
        end
    end

endmodule

// File: rtl/lrsc_unit.sv
// Top of the load-reserved / store-conditional unit.
// Does: wires the decoder, the reservation register and the sequencer.
// Assumes: one instruction in flight at a time; clear_resv may arrive any cycle.
module lrsc_unit
    import lrsc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [31:0]     in_insn,
    input  logic [XLEN-1:0] in_rs1,
    input  logic [XLEN-1:0] in_rs2,
    input  logic            clear_resv,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic            mem_req_we,
    output logic            mem_req_dword,
    output logic [XLEN-1:0] mem_req_addr,
    output logic [XLEN-1:0] mem_req_wdata,
    output logic            mem_req_aq,
    output logic            mem_req_rl,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_rdata,
    output logic            rf_we,
    output logic [4:0]      rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            misaligned,
    output logic            illegal
);

    dec_t            dec;
    logic            hit;
    logic            consume;
    logic            set_en;
    logic [XLEN-1:0] set_addr;
    logic            set_dword;

    lrsc_decode u_dec (
        .insn (in_insn),
        .dec  (dec)
    );

    lrsc_resv #(.AW(XLEN)) u_resv (
        .clk         (clk),
        .rst_n       (rst_n),
        .drop_i      (clear_resv),
        .consume_i   (consume),
        .set_i       (set_en),
        .set_addr_i  (set_addr),
        .set_dword_i (set_dword),
        .chk_addr_i  (in_rs1),
        .chk_dword_i (dec.dword),
        .hit_o       (hit)
    );

    lrsc_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .dec           (dec),
        .rs1           (in_rs1),
        .rs2           (in_rs2),
        .hit_i         (hit),
        .consume_o     (consume),
        .set_o         (set_en),
        .set_addr_o    (set_addr),
        .set_dword_o   (set_dword),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_we    (mem_req_we),
        .mem_req_dword (mem_req_dword),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_req_aq    (mem_req_aq),
        .mem_req_rl    (mem_req_rl),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .rf_we         (rf_we),
        .rf_waddr      (rf_waddr),
        .rf_wdata      (rf_wdata),
        .misaligned    (misaligned),
        .illegal       (illegal)
    );

endmodule

// File: rtl/lrsc_checker.sv
// Port-level properties of lrsc_unit, attached with bind.
module lrsc_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic            mem_req_we,
    input logic            mem_req_dword,
    input logic [XLEN-1:0] mem_req_addr,
    input logic [XLEN-1:0] mem_req_wdata,
    input logic            mem_req_aq,
    input logic            mem_req_rl,
    input logic            rf_we,
    input logic [XLEN-1:0] rf_wdata,
    input logic            misaligned,
    input logic            illegal
);

    // R2: a stalled request keeps every field
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid
            && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_dword)
            && $stable(mem_req_wdata) && $stable(mem_req_aq) && $stable(mem_req_rl));

    // R10: no request ever leaves with an address unaligned for its size
    p_req_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_dword ? (mem_req_addr[2:0] == 3'd0)
                                         : (mem_req_addr[1:0] == 2'd0)));

    // R7: a word write carries nothing in the upper half
    p_word_wdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we && !mem_req_dword |-> (mem_req_wdata[63:32] == 32'd0));

    // R5: the first cycle of a write coincides with a success status on rd
    p_status_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid && mem_req_we) |-> rf_we && (rf_wdata == '0));

    // R1: result, misaligned and illegal strobes are mutually exclusive
    p_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, misaligned, illegal}));

    // R11: no request while the unit reports idle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !mem_req_valid);

endmodule

bind lrsc_unit lrsc_checker #(.XLEN(XLEN)) u_lrsc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_ready      (in_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_dword (mem_req_dword),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_req_aq    (mem_req_aq),
    .mem_req_rl    (mem_req_rl),
    .rf_we         (rf_we),
    .rf_wdata      (rf_wdata),
    .misaligned    (misaligned),
    .illegal       (illegal)
);

// File: tb/test_lrsc_unit.sv
`timescale 1ns/1ps
module test_lrsc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_insn = '0;
    logic [63:0] in_rs1 = '0;
    logic [63:0] in_rs2 = '0;
    logic        clear_resv = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_we;
    logic        mem_req_dword;
    logic [63:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_req_aq;
    logic        mem_req_rl;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [63:0] rf_wdata;
    logic        misaligned;
    logic        illegal;

    int checks = 0;
    int failures = 0;

    // reference reservation
    bit          ref_v = 0;
    logic [63:0] ref_a = '0;
    bit          ref_dw = 0;

    // observations of one operation
    int          n_req, req_cyc, rf_cyc;
    bit          rf_seen, ill_seen, mis_seen, timed_out;
    logic [63:0] rf_val, cap_addr, cap_wdata;
    logic [4:0]  rf_idx;
    bit          cap_we, cap_dw, cap_aq, cap_rl;

    always #2 clk = ~clk;

    lrsc_unit i_lrsc_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_insn(in_insn), .in_rs1(in_rs1), .in_rs2(in_rs2), .clear_resv(clear_resv),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_dword(mem_req_dword),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_aq(mem_req_aq), .mem_req_rl(mem_req_rl),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .misaligned(misaligned), .illegal(illegal)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] f5, input bit aq, input bit rl,
                                       input logic [4:0] s2, input logic [2:0] f3,
                                       input logic [4:0] rd, input logic [6:0] opc);
        return {f5, aq, rl, s2, 5'd10, f3, rd, opc};
    endfunction

    function automatic logic [31:0] lr_i(input bit dw, input bit aq, input bit rl, input logic [4:0] rd);
        return mk(5'b00010, aq, rl, 5'd0, dw ? 3'b011 : 3'b010, rd, 7'b0101111);
    endfunction

    function automatic logic [31:0] sc_i(input bit dw, input bit aq, input bit rl, input logic [4:0] rd);
        return mk(5'b00011, aq, rl, 5'd7, dw ? 3'b011 : 3'b010, rd, 7'b0101111);
    endfunction

    function automatic logic [63:0] mem_of(input logic [63:0] a);
        return {a[31:0] ^ 32'hC3A5_5A3C, ~a[31:0] + 32'h1234};
    endfunction

    // bench-side classification: 0 LR, 1 SC, 2 bad
    function automatic int kind_of(input logic [31:0] w);
        bit ok;
        ok = (w[6:0] == 7'b0101111) && (w[14:12] == 3'b010 || w[14:12] == 3'b011);
        if (ok && w[31:27] == 5'b00010 && w[24:20] == 5'd0) return 0;
        if (ok && w[31:27] == 5'b00011) return 1;
        return 2;
    endfunction

    task automatic do_op(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                         input bit clr_acc, input bit clr_rsp);
        int  k;
        bit  dw, al, waiting, done, succ;
        int  dly;
        logic [63:0] exp;
        k  = kind_of(w);
        dw = (w[14:12] == 3'b011);
        al = dw ? (a[2:0] == 0) : (a[1:0] == 0);
        n_req = 0; req_cyc = -1; rf_cyc = -1; rf_seen = 0; ill_seen = 0; mis_seen = 0;
        rf_val = '0; rf_idx = '0; timed_out = 1; waiting = 0; dly = 0; done = 0;
        cap_addr = '0; cap_wdata = '0; cap_we = 0; cap_dw = 0; cap_aq = 0; cap_rl = 0;
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_insn = w; in_rs1 = a; in_rs2 = b; clear_resv = clr_acc;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0; clear_resv = 0;
        for (int c = 0; c < 60; c++) begin
            bit rdy;
            if (rf_we) begin rf_seen = 1; rf_val = rf_wdata; rf_idx = rf_waddr; rf_cyc = c; end
            if (illegal) ill_seen = 1;
            if (misaligned) mis_seen = 1;
            if (mem_req_valid && req_cyc < 0) req_cyc = c;
            done = in_ready;
            mem_rsp_valid = 0; clear_resv = 0;
            rdy = ($urandom_range(0, 3) != 0);
            if (mem_req_valid && rdy) begin
                n_req++;
                cap_addr = mem_req_addr; cap_wdata = mem_req_wdata; cap_we = mem_req_we;
                cap_dw = mem_req_dword; cap_aq = mem_req_aq; cap_rl = mem_req_rl;
                if (!mem_req_we) begin waiting = 1; dly = $urandom_range(0, 3); end
            end else if (waiting) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1; mem_rsp_rdata = mem_of(cap_addr);
                    clear_resv = clr_rsp; waiting = 0;
                end else dly--;
            end
            mem_req_ready = rdy;
            if (done) begin timed_out = 0; break; end
            @(negedge clk);
        end
        mem_req_ready = 0;
        chk(!timed_out, "R11 completion", 64'(timed_out), 64'd0);
        if (clr_acc) ref_v = 0;
        if (k == 2) begin
            chk(ill_seen, "R1 illegal flag", 64'(ill_seen), 64'd1);
            chk(n_req == 0 && !rf_seen, "R1 no side effect", 64'(n_req), 64'd0);
        end else if (!al) begin
            chk(mis_seen, "R10 misaligned flag", 64'(mis_seen), 64'd1);
            chk(n_req == 0 && !rf_seen, "R10 no side effect", 64'(n_req), 64'd0);
        end else if (k == 0) begin
            chk(n_req == 1 && !cap_we, "R2 one read", 64'(n_req), 64'd1);
            chk(cap_addr == a && cap_dw == dw, "R2 read address/size", cap_addr, a);
            chk(cap_aq == w[26] && cap_rl == w[25], "R2 ordering bits",
                {62'd0, cap_aq, cap_rl}, {62'd0, w[26], w[25]});
            exp = dw ? mem_of(a) : {{32{mem_of(a)[31]}}, mem_of(a)[31:0]};
            chk(rf_seen && rf_idx == w[11:7], "R3 rd index", 64'(rf_idx), 64'(w[11:7]));
            chk(rf_val == exp, "R3 load value", rf_val, exp);
            if (clr_rsp) ref_v = 0;
            else begin ref_v = 1; ref_a = a; ref_dw = dw; end
        end else begin
            succ = ref_v && ref_a == a && ref_dw == dw;
            chk(rf_seen && rf_val == (succ ? 64'd0 : 64'd1), "R4/R5 sc status",
                rf_val, succ ? 64'd0 : 64'd1);
            chk(rf_seen && rf_idx == w[11:7], "R5 rd index", 64'(rf_idx), 64'(w[11:7]));
            chk(n_req == (succ ? 1 : 0), "R6 request count", 64'(n_req), succ ? 64'd1 : 64'd0);
            if (succ) begin
                exp = dw ? b : {32'd0, b[31:0]};
                chk(rf_cyc <= req_cyc, "R5 status before write", 64'(rf_cyc), 64'(req_cyc));
                chk(cap_we && cap_addr == a && cap_dw == dw, "R7 write address", cap_addr, a);
                chk(cap_wdata == exp, "R7 write data", cap_wdata, exp);
                chk(cap_aq == w[26] && cap_rl == w[25], "R7 ordering bits",
                    {62'd0, cap_aq, cap_rl}, {62'd0, w[26], w[25]});
            end
            ref_v = 0;  // R8
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    localparam logic [63:0] A = 64'h0000_0000_8000_1000;

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        chk(in_ready == 1, "R11 ready after reset", 64'(in_ready), 64'd1);
        chk(!mem_req_valid && !rf_we, "R11 quiet after reset", 64'(mem_req_valid), 64'd0);
        // R4: no reservation after reset
        do_op(sc_i(0, 0, 0, 5'd3), A, 64'h1, 0, 0);
        // R3/R7: word pair with negative load data
        do_op(lr_i(0, 1, 0, 5'd4), A, 64'h0, 0, 0);
        do_op(sc_i(0, 1, 1, 5'd5), A, 64'hFFFF_EEEE_1234_5678, 0, 0);
        // R8: second SC fails
        do_op(sc_i(0, 0, 1, 5'd5), A, 64'h9, 0, 0);
        // R4: size mismatch
        do_op(lr_i(1, 0, 0, 5'd6), A, 64'h0, 0, 0);
        do_op(sc_i(0, 0, 0, 5'd6), A, 64'h2, 0, 0);
        // R4: address mismatch
        do_op(lr_i(1, 0, 1, 5'd7), A, 64'h0, 0, 0);
        do_op(sc_i(1, 0, 0, 5'd7), A + 8, 64'h3, 0, 0);
        // R9: clear at SC acceptance
        do_op(lr_i(1, 0, 0, 5'd8), A, 64'h0, 0, 0);
        do_op(sc_i(1, 0, 0, 5'd8), A, 64'h4, 1, 0);
        // R9: clear in the response cycle wins
        do_op(lr_i(0, 0, 0, 5'd9), A, 64'h0, 0, 1);
        do_op(sc_i(0, 0, 0, 5'd9), A, 64'h5, 0, 0);
        // R10: misaligned SC keeps the reservation, then a real SC succeeds
        do_op(lr_i(1, 1, 1, 5'd10), A, 64'h0, 0, 0);
        do_op(sc_i(1, 0, 0, 5'd10), A + 4, 64'h6, 0, 0);
        do_op(sc_i(1, 1, 0, 5'd10), A, 64'hDEAD_BEEF_CAFE_F00D, 0, 0);
        // R1: wrong size code, LR with nonzero rs2 field, wrong opcode
        do_op(mk(5'b00010, 0, 0, 5'd0, 3'b000, 5'd1, 7'b0101111), A, 64'h0, 0, 0);
        do_op(mk(5'b00010, 0, 0, 5'd3, 3'b010, 5'd1, 7'b0101111), A, 64'h0, 0, 0);
        do_op(mk(5'b00011, 0, 0, 5'd0, 3'b010, 5'd1, 7'b0100011), A, 64'h0, 0, 0);
        // mixed random traffic
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a;
            logic [31:0] w;
            int sel;
            bit dw;
            sel = $urandom_range(0, 9);
            dw  = $urandom_range(0, 1);
            case ($urandom_range(0, 5))
                0: a = A; 1: a = A + 4; 2: a = A + 8; 3: a = A + 16; 4: a = A + 2; default: a = A + 6;
            endcase
            if (sel < 4) w = lr_i(dw, $urandom_range(0, 1), $urandom_range(0, 1), 5'($urandom_range(0, 31)));
            else if (sel < 9) begin
                if (ref_v && $urandom_range(0, 1)) begin a = ref_a; dw = ref_dw; end
                w = sc_i(dw, $urandom_range(0, 1), $urandom_range(0, 1), 5'($urandom_range(0, 31)));
            end else w = mk(5'($urandom_range(0, 31)), 0, 0, 5'd0, 3'b001, 5'd2, 7'b0101111);
            do_op(w, a, {$urandom, $urandom}, ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule